// File: doc/BRIEF.md
# Pointer-Chasing Prefetch Engine

This block walks a linked structure in memory on its own, apart from the processor, and places what it finds into a small fully associative prefetch buffer. The processor programs a start node, picks a traversal kernel and, for lookups, supplies a search key, all through a plain register write port. The engine then follows the chain of next pointers one node at a time. For each node it loads one payload word and stores that word in the buffer, tagged with the node's address. It stops at a null pointer or, for the keyed kernels, at the node whose key field equals the search key.

The processor later presents node addresses on a lookup port. A hit returns the buffered payload and frees the entry. The engine throttles itself against buffer occupancy: it will not start a new node while the number of entries is at or above a programmable high-water mark. It carries on as soon as lookups bring the count below that mark. If a new start node is written during a walk, the walk is abandoned and a new one begins from the new node.

The memory side uses valid/ready. A request holds `mreq_valid` and `mreq_addr` steady until `mreq_ready` is seen at a clock edge. Only one load is ever outstanding. The engine raises `mrsp_ready` only while it waits for the reply to that load, and a reply is taken on the edge where `mrsp_valid` and `mrsp_ready` are both high.

Top module: `ptr_chase_pf`

## Requirements
- R1: After reset the engine is idle with `walk_busy`=0 and `walk_done`=0, the buffer is empty (`pf_count`=0) and `mreq_valid`=0.
- R2: Register writes select the target with `cfg_sel`: 0 is the start node address, 1 the kernel id (low bits of the data), 2 the search key, 3 the high-water mark (low 6 bits, reset value 8). Writing the start node begins a walk, which uses the kernel id and key that are held at that moment.
- R3: The kernel ids decode to fixed byte offsets within a node. Kernel 0 is a list walk with data at +0 and next at +4. Kernel 1 is keyed, with key at +0, data at +4 and next at +8. Kernel 2 is a list walk with next at +0 and data at +8. Kernel 3 is keyed, with next at +0, key at +4 and data at +8.
- R4: For each node the engine issues loads in this order: the data word, then the key word (keyed kernels only), then the next pointer. The loaded next pointer becomes the following node's address.
- R5: A next pointer of zero ends the walk: `walk_done` goes to 1 and `walk_busy` to 0. A start node of zero ends the walk at once, with no memory request.
- R6: In a keyed kernel, a node whose key word equals the search key ends the walk after that node's data and key loads. No next load is issued for it.
- R7: Every data load places {node address, data} into the buffer. A lookup (`lk_req`) is answered one cycle later on `lk_rsp_valid`: on a hit `lk_rsp_hit`=1, the data appears on `lk_rsp_data` and the entry is removed; on a miss `lk_rsp_hit`=0.
- R8: No data load for a new node is issued while `pf_count` is at or above the high-water mark. The walk continues once lookups bring the count below the mark.
- R9: The buffer holds 32 entries. A push into a full buffer evicts the oldest entry.
- R10: Writing the start node during a walk aborts that walk. A load already issued completes and its reply is discarded, and the engine then walks from the new node.
- R11: A memory request stays valid with a stable address until accepted, and no new request is raised while a reply is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (R2 encoding) |
| cfg_wdata | input | 32 | Register write data |
| mreq_valid | output | 1 | Memory load request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Byte address of the load |
| mrsp_valid | input | 1 | Load reply valid |
| mrsp_ready | output | 1 | Engine awaits a reply |
| mrsp_data | input | 32 | Loaded word |
| lk_req | input | 1 | Processor lookup strobe |
| lk_addr | input | 32 | Node address being looked up |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_rsp_hit | output | 1 | Lookup found the node |
| lk_rsp_data | output | 32 | Payload on a hit, zero on a miss |
| pf_count | output | 6 | Number of buffered entries |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | Last walk has ended |

## Verification
The assertions assume that memory replies only to a load it has accepted, exactly once and in order, and that it never raises `mrsp_valid` unless the engine shows `mrsp_ready`. The bench's memory model grants one request at a time after a programmable gap and replies after a programmable latency. It offers a reply only while no earlier reply is pending. The stimulus places nodes only at nonzero word-aligned addresses inside the modelled memory, and the walked lists are acyclic, so each walk ends by a null pointer, a key match or an abort.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

  localparam int OFF_W = 8;

  localparam logic [1:0] SEL_ROOT = 2'd0;
  localparam logic [1:0] SEL_KID  = 2'd1;
  localparam logic [1:0] SEL_KEY  = 2'd2;
  localparam logic [1:0] SEL_HWM  = 2'd3;

  typedef enum logic [1:0] {PH_DATA, PH_KEY, PH_NEXT} phase_e;
  typedef enum logic [1:0] {WS_IDLE, WS_ROOM, WS_ISSUE, WS_AWAIT} wstate_e;

  // One kernel: the recurrent load (next) plus the non-recurrent loads.
  typedef struct packed {
    logic             keyed;
    logic [OFF_W-1:0] key_off;
    logic [OFF_W-1:0] data_off;
    logic [OFF_W-1:0] next_off;
  } kdesc_t;

  function automatic kdesc_t kernel_desc(input int unsigned k);
    kdesc_t d;
    case (k % 4)
      0:       d = '{keyed: 1'b0, key_off: 8'd0, data_off: 8'd0, next_off: 8'd4};
      1:       d = '{keyed: 1'b1, key_off: 8'd0, data_off: 8'd4, next_off: 8'd8};
      2:       d = '{keyed: 1'b0, key_off: 8'd0, data_off: 8'd8, next_off: 8'd0};
      default: d = '{keyed: 1'b1, key_off: 8'd4, data_off: 8'd8, next_off: 8'd0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pcp_cfg.sv
module pcp_cfg
  import pcp_pkg::*;
#(
  parameter int W       = 32,
  parameter int CNT_W   = 6,
  parameter int KID_W   = 2,
  parameter int DEF_HWM = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [W-1:0]     cfg_wdata,
  output logic [W-1:0]     root,
  output logic [KID_W-1:0] kid,
  output logic [W-1:0]     key,
  output logic [CNT_W-1:0] hwm,
  output logic             start
);

  // start is delayed one cycle so the walker sees the new root value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root  <= '0;
      kid   <= '0;
      key   <= '0;
      hwm   <= CNT_W'(DEF_HWM);
      start <= 1'b0;
    end else begin
      start <= cfg_we && (cfg_sel == SEL_ROOT);
      if (cfg_we) begin
        case (cfg_sel)
          SEL_ROOT: root <= cfg_wdata;
          SEL_KID:  kid  <= cfg_wdata[KID_W-1:0];
          SEL_KEY:  key  <= cfg_wdata;
          default:  hwm  <= cfg_wdata[CNT_W-1:0];
        endcase
      end
    end
  end

endmodule

// File: rtl/pcp_ktable.sv
module pcp_ktable
  import pcp_pkg::*;
#(
  parameter int NUM_K = 4,
  parameter int KID_W = 2
) (
  input  logic [KID_W-1:0] kid,
  output kdesc_t           desc
);

  kdesc_t tbl [NUM_K];

  for (genvar k = 0; k < NUM_K; k++) begin : g_kern
    assign tbl[k] = kernel_desc(k);
  end

  assign desc = tbl[kid];

endmodule

// File: rtl/pcp_walker.sv
module pcp_walker
  import pcp_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     root,
  input  logic [W-1:0]     key,
  input  kdesc_t           desc,
  input  logic [CNT_W-1:0] hwm,
  input  logic [CNT_W-1:0] occ,
  output logic             mreq_valid,
  input  logic             mreq_ready,
  output logic [W-1:0]     mreq_addr,
  input  logic             mrsp_valid,
  output logic             mrsp_ready,
  input  logic [W-1:0]     mrsp_data,
  output logic             push_valid,
  output logic [W-1:0]     push_tag,
  output logic [W-1:0]     push_data,
  output logic             busy,
  output logic             done
);

  wstate_e          state;
  phase_e           phase;
  logic [W-1:0]     node_q;
  logic [W-1:0]     key_q;
  kdesc_t           kd_q;
  logic             restart_q;
  logic             abort_now;
  logic             go;
  logic             rsp_take;
  logic [OFF_W-1:0] off;

  assign abort_now = restart_q | start;
  assign rsp_take  = (state == WS_AWAIT) && mrsp_valid;
  assign go = abort_now && ((state == WS_IDLE) || (state == WS_ROOM) || rsp_take);

  always_comb begin
    case (phase)
      PH_DATA: off = kd_q.data_off;
      PH_KEY:  off = kd_q.key_off;
      default: off = kd_q.next_off;
    endcase
  end

  assign mreq_valid = (state == WS_ISSUE);
  assign mreq_addr  = node_q + W'(off);
  assign mrsp_ready = (state == WS_AWAIT);
  assign busy       = (state != WS_IDLE);

  assign push_valid = rsp_take && !abort_now && (phase == PH_DATA);
  assign push_tag   = node_q;
  assign push_data  = mrsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      phase     <= PH_DATA;
      node_q    <= '0;
      key_q     <= '0;
      kd_q      <= '0;
      restart_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      restart_q <= abort_now && !go;
      if (go) begin
        node_q <= root;
        key_q  <= key;
        kd_q   <= desc;
        phase  <= PH_DATA;
        done   <= (root == '0);
        state  <= (root == '0) ? WS_IDLE : WS_ROOM;
      end else begin
        case (state)
          WS_ROOM: begin
            if (occ < hwm) begin
              phase <= PH_DATA;
              state <= WS_ISSUE;
            end
          end
          WS_ISSUE: begin
            if (mreq_ready) state <= WS_AWAIT;
          end
          WS_AWAIT: begin
            if (mrsp_valid) begin
              case (phase)
                PH_DATA: begin
                  phase <= kd_q.keyed ? PH_KEY : PH_NEXT;
                  state <= WS_ISSUE;
                end
                PH_KEY: begin
                  if (mrsp_data == key_q) begin
                    done  <= 1'b1;
                    state <= WS_IDLE;
                  end else begin
                    phase <= PH_NEXT;
                    state <= WS_ISSUE;
                  end
                end
                default: begin
                  if (mrsp_data == '0) begin
                    done  <= 1'b1;
                    state <= WS_IDLE;
                  end else begin
                    node_q <= mrsp_data;
                    state  <= WS_ROOM;
                  end
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: request held stable until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr));

  // R11: never a new request while a reply is awaited
  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_ready |-> !mreq_valid);

  // R8: a node's data load starts only below the high-water mark
  p_throttle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ISSUE) && (phase == PH_DATA) && ($past(state) == WS_ROOM)
      |-> $past(occ < hwm));

  // R5: done only when idle
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: null next pointer ends the walk
  p_null_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !abort_now && (phase == PH_NEXT) && (mrsp_data == '0)
      |=> done && !busy);

  // R6: key match ends a keyed walk
  p_key_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !abort_now && (phase == PH_KEY) && (mrsp_data == key_q)
      |=> done && !busy);

endmodule

// File: rtl/pcp_buffer.sv
module pcp_buffer #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [W-1:0]     push_tag,
  input  logic [W-1:0]     push_data,
  input  logic             lk_req,
  input  logic [W-1:0]     lk_addr,
  output logic             lk_rsp_valid,
  output logic             lk_rsp_hit,
  output logic [W-1:0]     lk_rsp_data,
  output logic [CNT_W-1:0] occ
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    logic [W-1:0] tag;
    logic [W-1:0] data;
  } ent_t;

  // Entries 0..occ-1 are live, index 0 is the oldest.
  ent_t             ent_q [DEPTH];
  ent_t             rm    [DEPTH];
  ent_t             ev    [DEPTH];
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] shift_rm;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic [CNT_W-1:0] cnt_rm;
  logic             evict;
  logic [CNT_W-1:0] slot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i]  = lk_req && (CNT_W'(i) < occ) && (ent_q[i].tag == lk_addr);
    assign shift_rm[i] = hit_any && (IDX_W'(i) >= hit_idx);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign cnt_rm = occ - CNT_W'(hit_any);
  assign evict  = push_valid && (cnt_rm == CNT_W'(DEPTH));
  assign slot   = evict ? CNT_W'(DEPTH - 1) : cnt_rm;

  // Removal closes the gap, then eviction drops index 0.
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign rm[i] = shift_rm[i] ? ent_q[i+1] : ent_q[i];
      assign ev[i] = evict ? rm[i+1] : rm[i];
    end else begin : g_top
      assign rm[i] = ent_q[i];
      assign ev[i] = rm[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      occ          <= '0;
      lk_rsp_valid <= 1'b0;
      lk_rsp_hit   <= 1'b0;
      lk_rsp_data  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_q[i] <= (push_valid && (slot == CNT_W'(i))) ? '{tag: push_tag, data: push_data} : ev[i];
      end
      occ          <= cnt_rm + CNT_W'(push_valid) - CNT_W'(evict);
      lk_rsp_valid <= lk_req;
      lk_rsp_hit   <= hit_any;
      lk_rsp_data  <= hit_any ? ent_q[hit_idx].data : '0;
    end
  end

  // R9: count never exceeds capacity
  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R9: a push into a full buffer keeps it full
  p_evict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !lk_req && (occ == CNT_W'(DEPTH)) |=> occ == CNT_W'(DEPTH));

  // R7: every lookup is answered the next cycle
  p_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_rsp_valid);

  // R7: a hit frees one entry
  p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid && lk_rsp_hit && !$past(push_valid) |-> occ == $past(occ) - 1'b1);

endmodule

// File: rtl/ptr_chase_pf.sv
module ptr_chase_pf
  import pcp_pkg::*;
#(
  parameter int W       = 32,
  parameter int DEPTH   = 32,
  parameter int NUM_K   = 4,
  parameter int DEF_HWM = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  output logic         mreq_valid,
  input  logic         mreq_ready,
  output logic [W-1:0] mreq_addr,
  input  logic         mrsp_valid,
  output logic         mrsp_ready,
  input  logic [W-1:0] mrsp_data,
  input  logic         lk_req,
  input  logic [W-1:0] lk_addr,
  output logic         lk_rsp_valid,
  output logic         lk_rsp_hit,
  output logic [W-1:0] lk_rsp_data,
  output logic [$clog2(DEPTH+1)-1:0] pf_count,
  output logic         walk_busy,
  output logic         walk_done
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int KID_W = (NUM_K > 1) ? $clog2(NUM_K) : 1;

  logic [W-1:0]     root;
  logic [W-1:0]     key;
  logic [KID_W-1:0] kid;
  logic [CNT_W-1:0] hwm;
  logic             start;
  kdesc_t           desc;
  logic             push_valid;
  logic [W-1:0]     push_tag;
  logic [W-1:0]     push_data;

  pcp_cfg #(.W(W), .CNT_W(CNT_W), .KID_W(KID_W), .DEF_HWM(DEF_HWM)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .root(root), .kid(kid), .key(key),
    .hwm(hwm), .start(start)
  );

  pcp_ktable #(.NUM_K(NUM_K), .KID_W(KID_W)) u_ktable (
    .kid(kid), .desc(desc)
  );

  pcp_walker #(.W(W), .CNT_W(CNT_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .root(root), .key(key),
    .desc(desc), .hwm(hwm), .occ(pf_count),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .push_valid(push_valid), .push_tag(push_tag), .push_data(push_data),
    .busy(walk_busy), .done(walk_done)
  );

  pcp_buffer #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_buffer (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_tag(push_tag),
    .push_data(push_data), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit),
    .lk_rsp_data(lk_rsp_data), .occ(pf_count)
  );

  // R1: nothing requested while reset has just ended and no walk started
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_busy |-> !mreq_valid);

endmodule

// File: tb/ptr_chase_pf_bench.sv
`timescale 1ns/1ps
module ptr_chase_pf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mreq_valid, mreq_ready;
  logic [31:0] mreq_addr;
  logic        mrsp_valid, mrsp_ready;
  logic [31:0] mrsp_data;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_rsp_valid, lk_rsp_hit;
  logic [31:0] lk_rsp_data;
  logic [5:0]  pf_count;
  logic        walk_busy, walk_done;

  always #2.5 clk = ~clk;

  ptr_chase_pf u_ptr_chase_pf (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_data(mrsp_data),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_hit(lk_rsp_hit), .lk_rsp_data(lk_rsp_data), .pf_count(pf_count),
    .walk_busy(walk_busy), .walk_done(walk_done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem  [0:255];
  logic [31:0] rlog [0:511];
  int nreq = 0;
  int mem_lat = 1;
  int req_gap = 0;
  bit m_pend, m_hs;
  int m_lat, m_gap;
  logic [7:0] m_idx;

  initial begin
    mreq_ready = 1'b0; mrsp_valid = 1'b0; mrsp_data = '0;
    m_pend = 0; m_hs = 0; m_lat = 0; m_gap = 0; m_idx = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mreq_ready = 1'b0; mrsp_valid = 1'b0; m_pend = 0; m_hs = 0; m_gap = 0;
      end else begin
        if (m_hs) begin mrsp_valid = 1'b0; m_hs = 0; end
        if (mreq_ready) begin
          mreq_ready = 1'b0; m_pend = 1; m_lat = mem_lat;
        end else if (m_pend) begin
          if (m_lat > 0) m_lat--;
          else if (!mrsp_valid) begin
            mrsp_valid = 1'b1; mrsp_data = mem[m_idx]; m_pend = 0;
          end
        end else if (mreq_valid && !mrsp_valid) begin
          if (m_gap < req_gap) m_gap++;
          else begin
            m_gap = 0; mreq_ready = 1'b1; m_idx = mreq_addr[9:2];
            if (nreq < 512) rlog[nreq] = mreq_addr;
            nreq++;
          end
        end
        if (mrsp_valid && mrsp_ready) m_hs = 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; lk_req = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    nreq = 0; mem_lat = 1; req_gap = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    while (!(walk_done && !walk_busy) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(walk_done && !walk_busy, req, "walk ends", {30'd0, walk_busy, walk_done}, 32'h1);
  endtask

  task automatic lookup(input logic [31:0] a, output logic hit, output logic [31:0] d);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    hit = lk_rsp_hit && lk_rsp_valid;
    d = lk_rsp_data;
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[9:2]] = v;
  endtask

  function automatic logic [31:0] pay(input logic [31:0] a);
    return 32'hD000_0000 | a;
  endfunction

  // list for kernel 0: data at +0, next at +4
  task automatic mk_k0(input logic [31:0] base, input int n, input int stride);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = base + stride * i;
      put(a, pay(a));
      put(a + 4, (i == n - 1) ? 32'h0 : a + stride);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic h; logic [31:0] d;
    chk(walk_busy == 0, "R1", "busy after reset", walk_busy, 0);
    chk(walk_done == 0, "R1", "done after reset", walk_done, 0);
    chk(pf_count == 0, "R1", "count after reset", pf_count, 0);
    chk(mreq_valid == 0, "R1", "no request after reset", mreq_valid, 0);
    lookup(32'h100, h, d);
    chk(h == 0, "R7", "lookup in empty buffer misses", h, 0);
  endtask

  task automatic t_list();
    logic h; logic [31:0] d;
    logic [31:0] exp [6];
    do_reset();
    mem_lat = 2; req_gap = 1;
    put(32'h100, pay(32'h100)); put(32'h104, 32'h180);
    put(32'h180, pay(32'h180)); put(32'h184, 32'h140);
    put(32'h140, pay(32'h140)); put(32'h144, 32'h0);
    cfg(SEL_HWM_C, 32);
    cfg(SEL_KID_C, 0);
    cfg(SEL_ROOT_C, 32'h100);
    wait_done("R5");
    chk(pf_count == 3, "R7", "three entries pushed", pf_count, 3);
    chk(nreq == 6, "R4", "request count list walk", nreq, 6);
    exp = '{32'h100, 32'h104, 32'h180, 32'h184, 32'h140, 32'h144};
    for (int i = 0; i < 6; i++) chk(rlog[i] == exp[i], "R3", "kernel 0 request address", rlog[i], exp[i]);
    repeat (5) @(negedge clk);
    chk(nreq == 6 && mreq_valid == 0, "R11", "no request after walk", nreq, 6);
    lookup(32'h180, h, d);
    chk(h == 1 && d == pay(32'h180), "R7", "hit data middle node", d, pay(32'h180));
    chk(pf_count == 2, "R7", "hit frees entry", pf_count, 2);
    lookup(32'h180, h, d);
    chk(h == 0 && d == 0, "R7", "second lookup misses", {31'd0, h}, 0);
    lookup(32'h100, h, d);
    chk(h == 1 && d == pay(32'h100), "R7", "hit data first node", d, pay(32'h100));
    lookup(32'h140, h, d);
    chk(h == 1 && d == pay(32'h140), "R7", "hit data last node", d, pay(32'h140));
    chk(pf_count == 0, "R7", "buffer drained", pf_count, 0);
  endtask

  localparam logic [1:0] SEL_ROOT_C = 2'd0;
  localparam logic [1:0] SEL_KID_C  = 2'd1;
  localparam logic [1:0] SEL_KEY_C  = 2'd2;
  localparam logic [1:0] SEL_HWM_C  = 2'd3;

  // kernel 1: key +0, data +4, next +8
  task automatic mk_k1();
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = 32'h200 + 32'h40 * i;
      put(a, 11 * (i + 1));
      put(a + 4, pay(a));
      put(a + 8, (i == 3) ? 32'h0 : a + 32'h40);
    end
  endtask

  task automatic t_keyed();
    logic h; logic [31:0] d;
    do_reset();
    mk_k1();
    cfg(SEL_HWM_C, 32);
    cfg(SEL_KID_C, 1);
    cfg(SEL_KEY_C, 33);
    cfg(SEL_ROOT_C, 32'h200);
    wait_done("R6");
    chk(nreq == 8, "R6", "requests stop at key match", nreq, 8);
    chk(rlog[6] == 32'h284 && rlog[7] == 32'h280, "R4", "matched node data then key", rlog[7], 32'h280);
    chk(rlog[2] == 32'h208, "R3", "kernel 1 next offset", rlog[2], 32'h208);
    chk(pf_count == 3, "R6", "matched node is buffered", pf_count, 3);
    lookup(32'h2C0, h, d);
    chk(h == 0, "R6", "node past match not fetched", h, 0);
    lookup(32'h280, h, d);
    chk(h == 1 && d == pay(32'h280), "R6", "matched node data", d, pay(32'h280));
    // no match: walk runs to the null pointer
    do_reset();
    mk_k1();
    cfg(SEL_HWM_C, 32);
    cfg(SEL_KID_C, 1);
    cfg(SEL_KEY_C, 99);
    cfg(SEL_ROOT_C, 32'h200);
    wait_done("R5");
    chk(nreq == 12 && pf_count == 4, "R5", "keyed walk ends at null", nreq, 12);
  endtask

  task automatic t_kern23();
    logic [31:0] e2 [4];
    logic [31:0] e3 [3];
    do_reset();
    // kernel 2: next +0, data +8
    put(32'h300, 32'h340); put(32'h308, pay(32'h300));
    put(32'h340, 32'h0);   put(32'h348, pay(32'h340));
    cfg(SEL_HWM_C, 32);
    cfg(SEL_KID_C, 2);
    cfg(SEL_ROOT_C, 32'h300);
    wait_done("R3");
    e2 = '{32'h308, 32'h300, 32'h348, 32'h340};
    chk(nreq == 4, "R3", "kernel 2 request count", nreq, 4);
    for (int i = 0; i < 4; i++) chk(rlog[i] == e2[i], "R3", "kernel 2 address", rlog[i], e2[i]);
    // kernel 3: next +0, key +4, data +8
    do_reset();
    put(32'h380, 32'h0); put(32'h384, 32'd5); put(32'h388, pay(32'h380));
    cfg(SEL_KID_C, 3);
    cfg(SEL_KEY_C, 7);
    cfg(SEL_ROOT_C, 32'h380);
    wait_done("R3");
    e3 = '{32'h388, 32'h384, 32'h380};
    for (int i = 0; i < 3; i++) chk(rlog[i] == e3[i], "R3", "kernel 3 address", rlog[i], e3[i]);
    chk(pf_count == 1, "R2", "default high-water mark lets walk run", pf_count, 1);
  endtask

  task automatic t_null();
    do_reset();
    cfg(SEL_ROOT_C, 32'h0);
    wait_done("R5");
    repeat (4) @(negedge clk);
    chk(nreq == 0 && pf_count == 0, "R5", "null root issues nothing", nreq, 0);
  endtask

  task automatic t_throttle();
    logic h; logic [31:0] d;
    do_reset();
    mk_k0(32'h100, 5, 16);
    cfg(SEL_HWM_C, 2);
    cfg(SEL_KID_C, 0);
    cfg(SEL_ROOT_C, 32'h100);
    repeat (40) @(negedge clk);
    chk(walk_busy == 1 && pf_count == 2, "R8", "stalled at mark", pf_count, 2);
    chk(nreq == 4, "R8", "no load while at mark", nreq, 4);
    lookup(32'h100, h, d);
    repeat (40) @(negedge clk);
    chk(pf_count == 2 && nreq == 6, "R8", "one more node after consume", nreq, 6);
    lookup(32'h110, h, d);
    lookup(32'h120, h, d);
    wait_done("R8");
    chk(pf_count == 2 && nreq == 10, "R8", "walk finishes after draining", nreq, 10);
  endtask

  task automatic t_full();
    logic h; logic [31:0] d;
    do_reset();
    mk_k0(32'h100, 34, 8);
    cfg(SEL_HWM_C, 40);
    cfg(SEL_ROOT_C, 32'h100);
    wait_done("R9");
    chk(pf_count == 32, "R9", "buffer full", pf_count, 32);
    lookup(32'h100, h, d);
    chk(h == 0, "R9", "oldest evicted", h, 0);
    lookup(32'h108, h, d);
    chk(h == 0, "R9", "second oldest evicted", h, 0);
    lookup(32'h110, h, d);
    chk(h == 1 && d == pay(32'h110), "R9", "third node kept", d, pay(32'h110));
    lookup(32'h208, h, d);
    chk(h == 1 && d == pay(32'h208), "R9", "newest node kept", d, pay(32'h208));
  endtask

  task automatic t_abort();
    logic h; logic [31:0] d;
    logic [31:0] eb [6];
    int n_at;
    do_reset();
    mem_lat = 6;
    mk_k0(32'h100, 10, 8);
    mk_k0(32'h300, 3, 16);
    cfg(SEL_HWM_C, 32);
    cfg(SEL_ROOT_C, 32'h100);
    repeat (20) @(negedge clk);
    chk(walk_busy == 1, "R10", "first walk running", walk_busy, 1);
    n_at = nreq;
    cfg(SEL_ROOT_C, 32'h300);
    wait_done("R10");
    eb = '{32'h300, 32'h304, 32'h310, 32'h314, 32'h320, 32'h324};
    chk(nreq <= n_at + 7, "R10", "old walk stopped", nreq, n_at + 7);
    for (int i = 0; i < 6; i++)
      chk(rlog[nreq - 6 + i] == eb[i], "R10", "new walk requests", rlog[nreq - 6 + i], eb[i]);
    lookup(32'h148, h, d);
    chk(h == 0, "R10", "old list tail not fetched", h, 0);
    lookup(32'h320, h, d);
    chk(h == 1 && d == pay(32'h320), "R10", "new list node buffered", d, pay(32'h320));
  endtask

  // ---------------- run ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_list();
    t_keyed();
    t_kern23();
    t_null();
    t_throttle();
    t_full();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: act=%0h exp=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule